// File: doc/BRIEF.md
# Unordered Extended-Precision Compare Unit

This unit carries out the unordered compare of a floating-point register stack. It takes eight 80-bit extended-precision registers, a 3-bit stack-top pointer, a 16-bit tag word, a two-byte opcode and the invalid-operation mask. It compares the stack top with a second stack entry and reports the relation as condition codes. It raises an invalid-operand request when either operand is a signaling NaN or an encoding the format does not support. Depending on the opcode, it then pops the stack zero, one or two times. A quiet NaN gives an unordered result with no exception.

Requests arrive on a valid/ready input. The unit accepts one request per cycle and applies no back-pressure outside reset: `in_ready` is low only while `rst` is high. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. The opcode and all operand fields must be stable during that cycle. All results are registered and appear one cycle after the transfer. They hold until the next recognized request. `done` marks the cycle in which a fresh result is present.

Top module: `fcmp_unit`

## Requirements
- R1: While synchronous reset is active, and in the cycle after it, `cc` is 4'b0000, `ia_exc` is 0, `top_out` is 0, `tags_out` is 16'hFFFF and `done` is 0. `in_ready` is low while `rst` is high.
- R2: `cc` is {C3,C2,C1,C0}. For ordered operands it becomes 4'b0000 when ST(0) is greater than the source, 4'b0001 when it is less, and 4'b1000 when they are equal. C1 is cleared on every written result. Ordering is by value: sign-magnitude, with the magnitude order reversed when both operands are negative. Infinities and denormals take part in this order.
- R3: Positive and negative zero compare equal in any sign combination.
- R4: A quiet NaN has exponent bits [78:64] all ones, bit 63 set and bit 62 set. If either operand is a quiet NaN and neither raises R5, `cc` becomes 4'b1101 and `ia_exc` is 0.
- R5: Either of two encodings sets `ia_exc` to 1. The first is a signaling NaN: exponent all ones, bit 63 set, bit 62 clear and bits [61:0] nonzero. The second is an unsupported encoding: exponent nonzero, including all ones, with bit 63 clear. When `ia_mask` is 1, `cc` becomes 4'b1101.
- R6: When R5 applies and `ia_mask` is 0, `cc` keeps its previous value, `top_out` equals `top_in` and `tags_out` equals `tags_in`. No pop takes place.
- R7: With first byte 8'hDD, a second byte of 8'hE0+i compares with ST(i) and does not pop. A second byte of 8'hE8+i compares with ST(i) and pops once. The pair 8'hDA, 8'hE9 compares with ST(1) and pops twice. Any other opcode leaves every output unchanged and keeps `done` low.
- R8: ST(i) is register (top_in + i) mod 8. Register k occupies bits [80k+79:80k] of `regs`.
- R9: Each pop sets the 2-bit tag field of the current ST(0) to 2'b11 and increments the top pointer modulo 8. In a double pop, the second pop uses the incremented pointer. All other tag fields pass through from `tags_in`.
- R10: `done` is high exactly one cycle after a recognized request transfers. `ia_exc` is rewritten on every recognized request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| op_hi | input | 8 | First opcode byte |
| op_lo | input | 8 | Second opcode byte |
| regs | input | 640 | Eight physical 80-bit registers, register k at bits [80k+79:80k] |
| tags_in | input | 16 | Tag word, two bits per physical register |
| top_in | input | 3 | Current stack-top pointer |
| ia_mask | input | 1 | 1 = invalid-operand exception masked |
| done | output | 1 | Fresh result present |
| cc | output | 4 | Condition codes {C3,C2,C1,C0} |
| ia_exc | output | 1 | Invalid-operand exception request |
| top_out | output | 3 | Stack-top pointer after pops |
| tags_out | output | 16 | Tag word after pops |

## Verification
The bench goes after the zero-sign case. A design that compares raw bits would report 0000 or 0001 for -0 against +0. It also targets pairs of negative values: a design that omits the magnitude reversal reports -1 as less than -2. Quiet and signaling NaNs are separated by bit 62. An inverted test would raise the exception on quiet NaNs and stay silent on signaling ones. Unnormals and pseudo-infinities are also tested, because they are easily mistaken for finite values or infinities. Unmasked exceptions are checked for leaking condition codes or pops. The double pop is run across the pointer wrap from 7 to 0, where a second tag written at the old pointer or a pointer that fails to wrap shows up in `tags_out` and `top_out`. Undefined opcodes must not disturb the held state.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int FP_W  = 80;
  localparam int EXP_W = 15;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_FINITE,
    CL_INF,
    CL_QNAN,
    CL_SNAN,
    CL_UNSUP
  } fclass_e;

  typedef enum logic [1:0] {
    REL_GT,
    REL_LT,
    REL_EQ,
    REL_UN
  } rel_e;

  typedef struct packed {
    logic       ok;
    logic [2:0] idx;
    logic [1:0] pops;
  } dec_t;

  localparam logic [3:0] CC_GT = 4'b0000;
  localparam logic [3:0] CC_LT = 4'b0001;
  localparam logic [3:0] CC_EQ = 4'b1000;
  localparam logic [3:0] CC_UN = 4'b1101;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int W  = FP_W,
  parameter int EW = EXP_W
) (
  input  logic [W-1:0] val,
  output fclass_e      cls
);
  localparam int MW = W - 1 - EW;

  logic [EW-1:0] expo;
  logic          jbit;
  logic [MW-2:0] frac;

  assign expo = val[W-2 -: EW];
  assign jbit = val[MW-1];
  assign frac = val[MW-2:0];

  always_comb begin
    if (expo == '1) begin
      if (!jbit)                cls = CL_UNSUP;
      else if (frac == '0)      cls = CL_INF;
      else if (frac[MW-2])      cls = CL_QNAN;
      else                      cls = CL_SNAN;
    end else if (expo != '0) begin
      cls = jbit ? CL_FINITE : CL_UNSUP;
    end else begin
      cls = ({jbit, frac} == '0) ? CL_ZERO : CL_FINITE;
    end
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = FP_W
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  fclass_e      lcls,
  input  fclass_e      rcls,
  output rel_e         rel
);
  logic         lsign, rsign;
  logic [W-2:0] lmag, rmag;
  logic         l_nan, r_nan;

  assign lsign = lhs[W-1];
  assign rsign = rhs[W-1];
  assign lmag  = lhs[W-2:0];
  assign rmag  = rhs[W-2:0];
  assign l_nan = (lcls == CL_QNAN) || (lcls == CL_SNAN) || (lcls == CL_UNSUP);
  assign r_nan = (rcls == CL_QNAN) || (rcls == CL_SNAN) || (rcls == CL_UNSUP);

  always_comb begin
    if (l_nan || r_nan)                              rel = REL_UN;
    else if (lcls == CL_ZERO && rcls == CL_ZERO)     rel = REL_EQ;
    else if (lsign != rsign)                         rel = lsign ? REL_LT : REL_GT;
    else if (lmag == rmag)                           rel = REL_EQ;
    else if (lmag > rmag)                            rel = lsign ? REL_LT : REL_GT;
    else                                             rel = lsign ? REL_GT : REL_LT;
  end
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [7:0] op_hi,
  input  logic [7:0] op_lo,
  output dec_t       dec
);
  always_comb begin
    dec = '0;
    if (op_hi == 8'hDD && op_lo[7:3] == 5'b11100) begin
      dec.ok   = 1'b1;
      dec.idx  = op_lo[2:0];
      dec.pops = 2'd0;
    end else if (op_hi == 8'hDD && op_lo[7:3] == 5'b11101) begin
      dec.ok   = 1'b1;
      dec.idx  = op_lo[2:0];
      dec.pops = 2'd1;
    end else if (op_hi == 8'hDA && op_lo == 8'hE9) begin
      dec.ok   = 1'b1;
      dec.idx  = 3'd1;
      dec.pops = 2'd2;
    end
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = FP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          op_hi,
  input  logic [7:0]          op_lo,
  input  logic [NREG*W-1:0]   regs,
  input  logic [2*NREG-1:0]   tags_in,
  input  logic [$clog2(NREG)-1:0] top_in,
  input  logic                ia_mask,
  output logic                done,
  output logic [3:0]          cc,
  output logic                ia_exc,
  output logic [$clog2(NREG)-1:0] top_out,
  output logic [2*NREG-1:0]   tags_out
);
  localparam int PW = $clog2(NREG);
  localparam int TW = 2 * NREG;

  logic [W-1:0] entry [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign entry[k] = regs[k*W +: W];
  end

  dec_t          dec;
  logic [PW-1:0] src_ix, top_p1, top_n;
  logic [W-1:0]  opa, opb;
  fclass_e       cla, clb;
  rel_e          rel;
  logic          exc_c, blocked, acc;
  logic [3:0]    cc_n;
  logic [TW-1:0] tags_n;

  fcmp_decode u_dec (
    .op_hi (op_hi),
    .op_lo (op_lo),
    .dec   (dec)
  );

  assign src_ix = top_in + PW'(dec.idx);
  assign opa    = entry[top_in];
  assign opb    = entry[src_ix];

  fcmp_classify #(.W(W)) u_cla (.val(opa), .cls(cla));
  fcmp_classify #(.W(W)) u_clb (.val(opb), .cls(clb));

  fcmp_order #(.W(W)) u_ord (
    .lhs  (opa),
    .rhs  (opb),
    .lcls (cla),
    .rcls (clb),
    .rel  (rel)
  );

  assign in_ready = ~rst;
  assign acc      = in_valid & in_ready;
  assign exc_c    = (cla == CL_SNAN) || (cla == CL_UNSUP) ||
                    (clb == CL_SNAN) || (clb == CL_UNSUP);
  assign blocked  = exc_c & ~ia_mask;

  always_comb begin
    unique case (rel)
      REL_GT:  cc_n = CC_GT;
      REL_LT:  cc_n = CC_LT;
      REL_EQ:  cc_n = CC_EQ;
      default: cc_n = CC_UN;
    endcase
  end

  assign top_p1 = top_in + PW'(1);
  assign top_n  = top_in + PW'(dec.pops);

  always_comb begin
    tags_n = tags_in;
    if (dec.pops != 2'd0) tags_n[{top_in, 1'b0} +: 2] = 2'b11;
    if (dec.pops == 2'd2) tags_n[{top_p1, 1'b0} +: 2] = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      cc       <= 4'b0000;
      ia_exc   <= 1'b0;
      top_out  <= '0;
      tags_out <= '1;
    end else begin
      done <= acc & dec.ok;
      if (acc && dec.ok) begin
        ia_exc <= exc_c;
        if (blocked) begin
          top_out  <= top_in;
          tags_out <= tags_in;
        end else begin
          cc       <= cc_n;
          top_out  <= top_n;
          tags_out <= tags_n;
        end
      end
    end
  end

  AST_CC_HELD_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && exc_c && !ia_mask) |=> (cc == $past(cc))); // R6
  AST_MASKED_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && exc_c && ia_mask) |=> (ia_exc && cc == CC_UN)); // R5
  AST_QNAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && !exc_c && (cla == CL_QNAN || clb == CL_QNAN)) |=> (!ia_exc && cc == CC_UN)); // R4
  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && cla == CL_ZERO && clb == CL_ZERO) |=> (cc == CC_EQ)); // R3
  AST_C1_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && !blocked) |=> (cc[1] == 1'b0)); // R2
  AST_POP_TAG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok && !blocked && dec.pops != 2'd0) |=> (tags_out[{$past(top_in), 1'b0} +: 2] == 2'b11)); // R9
  AST_UNKNOWN_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(acc && dec.ok)) |=> ($stable(top_out) && $stable(tags_out) && $stable(cc) && !done)); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (acc && dec.ok) |=> done); // R10

endmodule

// File: tb/fcmp_unit_test.sv
`timescale 1ns/1ps
module fcmp_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   op_hi = 8'h00, op_lo = 8'h00;
  logic [639:0] regs = '0;
  logic [15:0]  tags_in = 16'h0000;
  logic [2:0]   top_in = 3'd0;
  logic         ia_mask = 1'b1;
  logic         done, ia_exc;
  logic [3:0]   cc;
  logic [2:0]   top_out;
  logic [15:0]  tags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [3:0]  m_cc   = 4'b0000;
  logic        m_exc  = 1'b0;
  logic [2:0]  m_top  = 3'd0;
  logic [15:0] m_tags = 16'hFFFF;

  always #4 clk = ~clk;

  fcmp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_hi(op_hi), .op_lo(op_lo), .regs(regs), .tags_in(tags_in),
    .top_in(top_in), .ia_mask(ia_mask), .done(done), .cc(cc),
    .ia_exc(ia_exc), .top_out(top_out), .tags_out(tags_out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  // 0 zero, 1 finite, 2 inf, 3 qnan, 4 snan, 5 unsupported
  function automatic int kind_of(input logic [79:0] v);
    logic [14:0] e = v[78:64];
    if (e != 15'd0 && !v[63]) return 5;
    if (e == 15'h7FFF) begin
      if (v[62:0] == 63'd0) return 2;
      return v[62] ? 3 : 4;
    end
    if (e == 15'd0 && v[63:0] == 64'd0) return 0;
    return 1;
  endfunction

  function automatic logic [80:0] order_key(input logic [79:0] v);
    logic [80:0] base = 81'd1 << 79;
    logic [80:0] mag  = {2'b00, v[78:0]};
    return v[79] ? (base - mag) : (base + mag);
  endfunction

  function automatic logic [79:0] rnd_val();
    int k = $urandom_range(0, 11);
    logic s = 1'($urandom);
    case (k)
      0: return mk(s, 15'd0, 64'd0);
      1: return mk(s, 15'h7FFF, 64'h8000_0000_0000_0000);
      2: return mk(s, 15'h7FFF, {2'b11, 30'd0, 32'($urandom)});
      3: return mk(s, 15'h7FFF, {2'b10, 30'd0, 32'($urandom) | 32'd1});
      4: return mk(s, 15'($urandom_range(1, 32767)), {1'b0, 31'($urandom), 32'($urandom)});
      5: return mk(s, 15'd0, {1'b0, 3'($urandom), 60'd0});
      default: return mk(s, 15'($urandom_range(16382, 16385)), {1'b1, 3'($urandom), 60'd0});
    endcase
  endfunction

  task automatic apply(input logic [7:0] hi, input logic [7:0] lo, input logic [2:0] tp,
                       input logic [15:0] tg, input logic msk, input logic [639:0] rf);
    logic ok; logic [2:0] ix; int pops;
    logic [79:0] a, b; int ka, kb; logic unord, exc, blk;
    logic [2:0] p1; string creq;
    @(negedge clk);
    in_valid = 1'b1; op_hi = hi; op_lo = lo; top_in = tp; tags_in = tg;
    ia_mask = msk; regs = rf;
    ok = 1'b0; ix = 3'd0; pops = 0;
    if (hi == 8'hDD && lo >= 8'hE0 && lo <= 8'hE7) begin ok = 1'b1; ix = lo[2:0]; pops = 0; end
    else if (hi == 8'hDD && lo >= 8'hE8 && lo <= 8'hEF) begin ok = 1'b1; ix = lo[2:0]; pops = 1; end
    else if (hi == 8'hDA && lo == 8'hE9) begin ok = 1'b1; ix = 3'd1; pops = 2; end
    p1 = tp + ix;
    a = rf[int'(tp)*80 +: 80];
    b = rf[int'(p1)*80 +: 80];
    ka = kind_of(a); kb = kind_of(b);
    unord = (ka >= 3) || (kb >= 3);
    exc   = (ka >= 4) || (kb >= 4);
    blk   = exc && !msk;
    creq  = "R2 R8";
    if (ka == 0 && kb == 0) creq = "R3";
    if (unord) creq = "R4";
    if (exc) creq = msk ? "R5" : "R6";
    if (ok) begin
      m_exc = exc;
      if (blk) begin
        m_top = tp; m_tags = tg;
      end else begin
        if (unord) m_cc = 4'b1101;
        else if (order_key(a) > order_key(b)) m_cc = 4'b0000;
        else if (order_key(a) < order_key(b)) m_cc = 4'b0001;
        else m_cc = 4'b1000;
        m_tags = tg; m_top = tp;
        for (int p = 0; p < pops; p++) begin
          m_tags[int'(m_top)*2 +: 2] = 2'b11;
          m_top = m_top + 3'd1;
        end
      end
    end
    @(negedge clk);
    check(ok ? "R10" : "R7", {15'd0, done}, {15'd0, ok});
    check(creq, {12'd0, cc}, {12'd0, m_cc});
    check(ok ? (exc ? "R5" : "R4") : "R7", {15'd0, ia_exc}, {15'd0, m_exc});
    check(blk ? "R6" : "R9", {13'd0, top_out}, {13'd0, m_top});
    check(blk ? "R6" : "R9", tags_out, m_tags);
    in_valid = 1'b0;
  endtask

  function automatic logic [639:0] fill();
    logic [639:0] r;
    for (int k = 0; k < 8; k++) r[k*80 +: 80] = rnd_val();
    return r;
  endfunction

  function automatic logic [639:0] put2(input logic [639:0] r, input int pa, input logic [79:0] va,
                                        input int pb, input logic [79:0] vb);
    logic [639:0] o = r;
    o[pa*80 +: 80] = va;
    o[pb*80 +: 80] = vb;
    return o;
  endfunction

  localparam logic [79:0] P_ONE  = {1'b0, 15'd16383, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P_TWO  = {1'b0, 15'd16384, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N_ONE  = {1'b1, 15'd16383, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N_TWO  = {1'b1, 15'd16384, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P_ZERO = 80'd0;
  localparam logic [79:0] N_ZERO = {1'b1, 79'd0};
  localparam logic [79:0] QNAN   = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0001};
  localparam logic [79:0] SNAN   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001};
  localparam logic [79:0] P_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P_MAX  = {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [79:0] PSINF  = {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000};
  localparam logic [79:0] UNNRM  = {1'b0, 15'd16383, 64'h4000_0000_0000_0000};
  localparam logic [79:0] DENRM  = {1'b0, 15'd0, 64'h0000_0000_0000_0010};

  initial begin
    #1_600_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [639:0] rf;
    void'($urandom(32'd20240611));
    rf = fill();
    repeat (3) @(negedge clk);
    check("R1", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {12'd0, cc}, 16'h0000);
    check("R1", {15'd0, ia_exc}, 16'd0);
    check("R1", {13'd0, top_out}, 16'd0);
    check("R1", tags_out, 16'hFFFF);
    check("R1", {15'd0, done}, 16'd0);
    check("R10", {15'd0, in_ready}, 16'd1);

    // R3: signed zeros
    apply(8'hDD, 8'hE1, 3'd2, 16'h0000, 1'b1, put2(rf, 2, N_ZERO, 3, P_ZERO));
    // R2: negative pair reversal and ordered cases
    apply(8'hDD, 8'hE2, 3'd5, 16'h0000, 1'b1, put2(rf, 5, N_ONE, 7, N_TWO));
    apply(8'hDD, 8'hE3, 3'd6, 16'h0000, 1'b1, put2(rf, 6, P_ONE, 1, P_TWO));
    apply(8'hDD, 8'hE1, 3'd0, 16'h0000, 1'b1, put2(rf, 0, P_INF, 1, P_MAX));
    apply(8'hDD, 8'hE1, 3'd0, 16'h0000, 1'b1, put2(rf, 0, P_ZERO, 1, DENRM));
    // R4: quiet NaN, unmasked, no exception
    apply(8'hDD, 8'hE1, 3'd0, 16'h0000, 1'b0, put2(rf, 0, QNAN, 1, P_ONE));
    // R2 again to set a known cc before blocked case
    apply(8'hDD, 8'hE1, 3'd0, 16'h0000, 1'b1, put2(rf, 0, P_TWO, 1, P_ONE));
    // R6: signaling NaN unmasked, pop form must not pop
    apply(8'hDD, 8'hE9, 3'd4, 16'h0000, 1'b0, put2(rf, 4, SNAN, 5, P_ONE));
    // R5: masked unsupported encodings
    apply(8'hDD, 8'hE9, 3'd4, 16'h0000, 1'b1, put2(rf, 4, PSINF, 5, P_ONE));
    apply(8'hDD, 8'hE1, 3'd4, 16'h0000, 1'b1, put2(rf, 4, P_ONE, 5, UNNRM));
    // R9: double pop across wrap
    apply(8'hDA, 8'hE9, 3'd7, 16'h0000, 1'b1, put2(rf, 7, P_ONE, 0, P_TWO));
    // R7: unknown opcodes hold state
    apply(8'hDD, 8'hF0, 3'd1, 16'h1234, 1'b1, rf);
    apply(8'hD8, 8'hE1, 3'd2, 16'h5555, 1'b1, rf);
    apply(8'hDA, 8'hE8, 3'd3, 16'h0F0F, 1'b1, rf);
    // R8: ST(0) compared with itself
    apply(8'hDD, 8'hE0, 3'd3, 16'h0000, 1'b1, put2(rf, 3, N_TWO, 3, N_TWO));

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] hi, lo; int sel;
      sel = $urandom_range(0, 19);
      if (sel < 8)       begin hi = 8'hDD; lo = 8'hE0 | 8'($urandom_range(0, 7)); end
      else if (sel < 16) begin hi = 8'hDD; lo = 8'hE8 | 8'($urandom_range(0, 7)); end
      else if (sel < 19) begin hi = 8'hDA; lo = 8'hE9; end
      else               begin hi = 8'($urandom); lo = 8'($urandom); end
      rf = fill();
      if ($urandom_range(0, 3) == 0) begin
        int t = $urandom_range(0, 7);
        rf[((t + 1) % 8)*80 +: 80] = rf[t*80 +: 80];
      end
      apply(hi, lo, 3'($urandom), 16'($urandom), 1'($urandom), rf);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule